// File: doc/BRIEF.md
# Serial Memory Slave Interface with Hold

This block is the device side of a four-wire serial memory link. A host drives a serial clock, an active-low select, a data input, an active-low hold and an active-low write-protect. The block returns serial data with an output-enable that stands for the high-impedance state of the data line. All pins are sampled by a faster system clock. Edges of the serial clock are found inside the block, so the block has a single clock domain and its outputs are registered.

Each selected frame starts with an 8-bit opcode. A read or write opcode is followed by a 24-bit address. A write then carries data bytes. The last complete byte is stored into a small on-chip byte store when select is released. The commit starts a fixed-length busy timer that stands in for a self-timed program cycle. A read streams bytes from the store and advances the address, which wraps. A status opcode returns the busy flag. Holding the hold pin low in mid-frame freezes the frame. Releasing it resumes the frame exactly where it stopped. The busy timer keeps running through hold and through deselect.

Top module: `spimem_front`

## Requirements
- R1: A frame starts only on a falling edge of `cs_n`. Serial clock edges and data while `cs_n` is high are discarded, change no stored byte, and leave `so_oe` low.
- R2: Data on `si` is captured on rising serial clock edges, MSB first. Opcode 0x02 followed by a 3-byte address (MSB first, only the low `ADDR_W` bits used) and a data byte stores that byte when `cs_n` rises.
- R3: `so` changes only after falling serial clock edges. Opcode 0x03 with a 3-byte address returns the stored byte MSB first, beginning after the falling edge that follows the 32nd rising edge.
- R4: While deselected, `so_oe` is low. After reset, `so_oe` is 0 and `standby` is 1.
- R5: After a committed write, `standby` stays 0 until the busy timer (`BUSY_CYCLES` system clocks) has run out, even though `cs_n` is high. It then returns to 1.
- R6: While the hold state is active, `so_oe` is 0 and serial clock edges and `si` are ignored. The frame continues unchanged after `hold_n` returns high.
- R7: The hold state is entered only while `cs_n` is low and `sck` is low. A low `hold_n` while `sck` is high keeps `so_oe` at 1 until `sck` falls.
- R8: The busy timer keeps counting while the hold state is active.
- R9: A write is not stored and does not start the busy timer while `wp_n` is low.
- R10: A write that ends while busy is set is not stored.
- R11: If `cs_n` rises part-way through a byte, no write is stored and the busy timer does not start.
- R12: A read advances the address after each byte and wraps from 2^`ADDR_W`-1 to 0.
- R13: Opcode 0x05 returns a status byte with busy in bit 0 and zeros in bits 7..1. It is sampled at each byte boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| si | input | 1 | Serial data in |
| hold_n | input | 1 | Active-low pause request |
| wp_n | input | 1 | Active-low write protect |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable; 0 models high impedance |
| standby | output | 1 | High when deselected and not busy |

## Verification
A bit counter that slips shows up as a returned byte that is shifted or wrong. This is seen at the first data byte of the next read, within about 40 serial clocks. A hold that is wrongly kept or lost is seen within two system clocks on `so_oe`, and as a corrupted byte once the frame resumes. Faults in the busy timer or the commit gating are seen on `standby` a few clocks after `cs_n` rises. They also appear as a stale or wrong value when the address is read back.

// File: rtl/spimem_pkg.sv
package spimem_pkg;
  localparam logic [7:0] OP_WRITE  = 8'h02;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_STATUS = 8'h05;

  typedef struct packed {
    logic sel;       // selected (registered cs_n low)
    logic cs_start;  // select just asserted
    logic cs_end;    // select just released
    logic rise;      // qualified rising serial edge
    logic fall;      // qualified falling serial edge
    logic si;        // sampled serial data
  } link_evt_t;
endpackage

// File: rtl/spimem_pins.sv
module spimem_pins
  import spimem_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sck,
  input  logic      cs_n,
  input  logic      si,
  input  logic      hold_n,
  input  logic      wp_n,
  output link_evt_t evt,
  output logic      held,
  output logic      wp_ok
);
  logic sck_q, sck_q2, csn_q, csn_q2, si_q, hold_q, wp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_q  <= 1'b0;
      sck_q2 <= 1'b0;
      csn_q  <= 1'b1;
      csn_q2 <= 1'b1;
      si_q   <= 1'b0;
      hold_q <= 1'b1;
      wp_q   <= 1'b0;
      held   <= 1'b0;
    end else begin
      sck_q  <= sck;
      sck_q2 <= sck_q;
      csn_q  <= cs_n;
      csn_q2 <= csn_q;
      si_q   <= si;
      hold_q <= hold_n;
      wp_q   <= wp_n;
      if (csn_q || hold_q)
        held <= 1'b0;
      else if (!sck_q)
        held <= 1'b1;
    end
  end

  always_comb begin
    evt.sel      = ~csn_q;
    evt.cs_start = csn_q2 & ~csn_q;
    evt.cs_end   = ~csn_q2 & csn_q;
    evt.rise     = sck_q & ~sck_q2 & ~csn_q & ~held;
    evt.fall     = ~sck_q & sck_q2 & ~csn_q & ~held;
    evt.si       = si_q;
  end

  assign wp_ok = wp_q;

  // R7: hold is only entered with select low and serial clock low
  p_hold_entry_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(held) |-> (!$past(sck_q) && !$past(csn_q)));
endmodule

// File: rtl/spimem_busy.sv
module spimem_busy #(
  parameter int BUSY_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(BUSY_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (start)
      cnt <= CW'(BUSY_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

  // R10: a new program cycle never starts over a running one
  p_no_restart_r10: assert property (@(posedge clk) disable iff (rst)
    start |-> (cnt == '0));
endmodule

// File: rtl/spimem_store.sv
module spimem_store #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    if (re)
      rdata <= mem[raddr];
  end
endmodule

// File: rtl/spimem_engine.sv
module spimem_engine
  import spimem_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  link_evt_t         evt,
  input  logic              wp_ok,
  input  logic              busy,
  input  logic [7:0]        rdata,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_raddr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [7:0]        ram_wdata,
  output logic              start_busy,
  output logic              so_bit
);
  logic [2:0]        bit_idx;
  logic [2:0]        byte_cnt;   // saturates at 4 (data phase)
  logic [6:0]        sreg;
  logic [7:0]        opcode;
  logic [ADDR_W-1:0] addr;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]        wr_byte;
  logic              wr_pend;
  logic [7:0]        tx_sh;
  logic [7:0]        out_byte;
  logic              rd_vld;

  logic [7:0]        in_byte;
  logic              byte_done;
  logic [ADDR_W-1:0] addr_full;
  logic              rd_first, rd_next, load_now;
  logic [7:0]        load_val;

  always_comb begin
    in_byte   = {sreg, evt.si};
    byte_done = evt.rise && (bit_idx == 3'd7);
    addr_full = ADDR_W'({addr, in_byte});
    rd_first  = byte_done && (byte_cnt == 3'd3) && (opcode == OP_READ);
    rd_next   = evt.fall && (bit_idx == 3'd0) && (byte_cnt == 3'd4) && (opcode == OP_READ);
    ram_re    = rd_first || rd_next;
    ram_raddr = rd_first ? addr_full : ptr + ADDR_W'(1);
    load_now  = evt.fall && (bit_idx == 3'd0) &&
                (((opcode == OP_READ) && (byte_cnt == 3'd4)) ||
                 ((opcode == OP_STATUS) && (byte_cnt != 3'd0)));
    load_val  = (opcode == OP_STATUS) ? {7'b0, busy} : out_byte;
    ram_we    = evt.cs_end && wr_pend && (bit_idx == 3'd0) && wp_ok && !busy;
    ram_waddr = addr;
    ram_wdata = wr_byte;
    start_busy = ram_we;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx  <= '0;
      byte_cnt <= '0;
      sreg     <= '0;
      opcode   <= '0;
      addr     <= '0;
      ptr      <= '0;
      wr_byte  <= '0;
      wr_pend  <= 1'b0;
      tx_sh    <= '0;
      out_byte <= '0;
      rd_vld   <= 1'b0;
      so_bit   <= 1'b0;
    end else begin
      rd_vld <= ram_re;
      if (rd_vld)
        out_byte <= rdata;
      if (evt.cs_start) begin
        bit_idx  <= '0;
        byte_cnt <= '0;
        opcode   <= '0;
        wr_pend  <= 1'b0;
        tx_sh    <= '0;
      end else begin
        if (evt.rise) begin
          sreg    <= {sreg[5:0], evt.si};
          bit_idx <= bit_idx + 3'd1;
          if (bit_idx == 3'd7) begin
            if (byte_cnt != 3'd4)
              byte_cnt <= byte_cnt + 3'd1;
            case (byte_cnt)
              3'd0:               opcode <= in_byte;
              3'd1, 3'd2, 3'd3:   addr   <= addr_full;
              default: if (opcode == OP_WRITE) begin
                wr_byte <= in_byte;
                wr_pend <= 1'b1;
              end
            endcase
          end
        end
        if (rd_first)
          ptr <= addr_full;
        else if (rd_next)
          ptr <= ptr + ADDR_W'(1);
        if (load_now) begin
          so_bit <= load_val[7];
          tx_sh  <= {load_val[6:0], 1'b0};
        end else if (evt.fall) begin
          so_bit <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  // R3: serial output moves only after a qualified falling edge
  p_so_on_fall_r3: assert property (@(posedge clk) disable iff (rst)
    !evt.fall |=> $stable(so_bit));
endmodule

// File: rtl/spimem_front.sv
module spimem_front
  import spimem_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 300
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  input  logic hold_n,
  input  logic wp_n,
  output logic so,
  output logic so_oe,
  output logic standby
);
  link_evt_t         evt;
  logic              held, wp_ok, busy, start_busy;
  logic              ram_re, ram_we;
  logic [ADDR_W-1:0] ram_raddr, ram_waddr;
  logic [7:0]        ram_wdata, rdata;

  spimem_pins u_pins (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .evt(evt), .held(held), .wp_ok(wp_ok)
  );

  spimem_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk(clk), .rst(rst), .evt(evt), .wp_ok(wp_ok), .busy(busy),
    .rdata(rdata), .ram_re(ram_re), .ram_raddr(ram_raddr),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .start_busy(start_busy), .so_bit(so)
  );

  spimem_store #(.ADDR_W(ADDR_W)) u_store (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .rdata(rdata)
  );

  spimem_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(start_busy), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      so_oe   <= 1'b0;
      standby <= 1'b1;
    end else begin
      so_oe   <= evt.sel & ~held;
      standby <= ~evt.sel & ~busy;
    end
  end

  // R4: a long-deselected device never drives the line
  p_deselect_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2)) |-> !so_oe);

  // R5: standby is withheld while the program timer runs
  p_standby_busy_r5: assert property (@(posedge clk) disable iff (rst)
    busy |=> !standby);

  // R6: hold releases the output line
  p_hold_tristate_r6: assert property (@(posedge clk) disable iff (rst)
    held |=> !so_oe);
endmodule

// File: tb/sim_spimem_front.sv
module sim_spimem_front;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 3;
  localparam int AW         = 8;
  localparam int BUSY       = 300;

  logic clk = 1'b0;
  logic rst, sck, cs_n, si, hold_n, wp_n;
  logic so, so_oe, standby;
  int checks = 0;
  int fails  = 0;
  int glitch = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spimem_front #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .hold_n(hold_n), .wp_n(wp_n), .so(so), .so_oe(so_oe), .standby(standby)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bits(logic [7:0] tx, int hi, int lo, inout logic [7:0] rx);
    for (int i = hi; i >= lo; i--) begin
      si = tx[i];
      wclk(H);
      rx[i] = so;
      sck = 1'b1;
      wclk(H);
      if (so !== rx[i]) glitch++;
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(logic [7:0] tx, output logic [7:0] rx);
    logic [7:0] r = 8'h00;
    bits(tx, 7, 0, r);
    rx = r;
  endtask

  task automatic sel();
    cs_n = 1'b0;
    wclk(H);
  endtask

  task automatic desel();
    wclk(H);
    cs_n = 1'b1;
    wclk(H);
  endtask

  task automatic head(logic [7:0] op, logic [23:0] a);
    logic [7:0] d;
    xbyte(op, d);
    xbyte(a[23:16], d);
    xbyte(a[15:8], d);
    xbyte(a[7:0], d);
  endtask

  task automatic wr(logic [23:0] a, logic [7:0] v);
    logic [7:0] d;
    sel();
    head(8'h02, a);
    xbyte(v, d);
    desel();
  endtask

  task automatic rd(logic [23:0] a, output logic [7:0] v);
    sel();
    head(8'h03, a);
    xbyte(8'h00, v);
    desel();
  endtask

  task automatic status(output logic [7:0] v);
    logic [7:0] d;
    sel();
    xbyte(8'h05, d);
    xbyte(8'h00, v);
    desel();
  endtask

  task automatic t_reset();
    chk("R4 reset so_oe", so_oe, 1'b0);
    chk("R4 reset standby", standby, 1'b1);
  endtask

  task automatic t_write_read();
    logic [7:0] v;
    wr(24'h000010, 8'hA5);
    wclk(BUSY + 10);
    wr(24'h000011, 8'h3C);
    wclk(BUSY + 10);
    glitch = 0;
    rd(24'h000010, v);
    chk("R2/R3 read back 0x10", v, 8'hA5);
    rd(24'h000011, v);
    chk("R2/R3 read back 0x11", v, 8'h3C);
    chk("R3 so stable while sck high", glitch, 0);
  endtask

  task automatic t_status_busy();
    logic [7:0] v;
    wr(24'h000040, 8'h66);
    chk("R5 standby low after commit", standby, 1'b0);
    status(v);
    chk("R13 status busy", v, 8'h01);
    wclk(BUSY / 3);
    chk("R5 standby still low while busy", standby, 1'b0);
    wclk(BUSY);
    chk("R5 standby back after timer", standby, 1'b1);
    status(v);
    chk("R13 status idle", v, 8'h00);
  endtask

  task automatic t_deselected();
    logic [7:0] d = 8'h00;
    logic [7:0] v;
    si = 1'b1;
    for (int k = 0; k < 5; k++) begin
      bits(8'h02, 7, 0, d);
      bits(8'h10, 7, 0, d);
    end
    chk("R1 no drive while deselected", so_oe, 1'b0);
    wclk(H);
    chk("R1 standby while deselected", standby, 1'b1);
    rd(24'h000010, v);
    chk("R1 stray bits change nothing", v, 8'hA5);
  endtask

  task automatic t_protect();
    logic [7:0] v;
    wp_n = 1'b0;
    wr(24'h000010, 8'h77);
    wp_n = 1'b1;
    chk("R9 no busy when protected", standby, 1'b1);
    rd(24'h000010, v);
    chk("R9 protected write dropped", v, 8'hA5);
  endtask

  task automatic t_busy_reject();
    logic [7:0] v;
    wr(24'h000020, 8'h11);
    wr(24'h000020, 8'h22);
    wclk(BUSY + 10);
    rd(24'h000020, v);
    chk("R10 write while busy dropped", v, 8'h11);
  endtask

  task automatic t_partial();
    logic [7:0] v;
    logic [7:0] d = 8'h00;
    wr(24'h000021, 8'h44);
    wclk(BUSY + 10);
    sel();
    head(8'h02, 24'h000021);
    bits(8'h99, 7, 0, d);
    bits(8'hF0, 7, 5, d);
    desel();
    chk("R11 partial byte starts no timer", standby, 1'b1);
    rd(24'h000021, v);
    chk("R11 partial byte not written", v, 8'h44);
  endtask

  task automatic t_hold_resume();
    logic [7:0] r = 8'h00;
    logic [7:0] junk = 8'h00;
    sel();
    head(8'h03, 24'h000010);
    bits(8'h00, 7, 5, r);
    hold_n = 1'b0;
    wclk(H);
    chk("R6 so_oe low in hold", so_oe, 1'b0);
    bits(8'hFF, 7, 2, junk);
    hold_n = 1'b1;
    wclk(H);
    chk("R6 so_oe back after hold", so_oe, 1'b1);
    bits(8'h00, 4, 0, r);
    desel();
    chk("R6 frame resumes intact", r, 8'hA5);
  endtask

  task automatic t_hold_entry();
    logic [7:0] r = 8'h00;
    sel();
    head(8'h03, 24'h000010);
    bits(8'h00, 7, 6, r);
    si = 1'b0;
    wclk(H);
    sck = 1'b1;
    wclk(H);
    hold_n = 1'b0;
    wclk(H);
    chk("R7 hold deferred while sck high", so_oe, 1'b1);
    sck = 1'b0;
    wclk(H);
    chk("R7 hold taken once sck low", so_oe, 1'b0);
    hold_n = 1'b1;
    desel();
  endtask

  task automatic t_hold_busy();
    logic [7:0] v;
    logic [7:0] d;
    wr(24'h000030, 8'h5A);
    sel();
    hold_n = 1'b0;
    wclk(BUSY + 20);
    hold_n = 1'b1;
    wclk(H);
    xbyte(8'h05, d);
    xbyte(8'h00, v);
    desel();
    chk("R8 timer ran during hold", v, 8'h00);
    rd(24'h000030, v);
    chk("R8 write stored", v, 8'h5A);
  endtask

  task automatic t_wrap();
    logic [7:0] a, b;
    wr(24'h0000FF, 8'hC3);
    wclk(BUSY + 10);
    wr(24'h000000, 8'h3C);
    wclk(BUSY + 10);
    sel();
    head(8'h03, 24'h0000FF);
    xbyte(8'h00, a);
    xbyte(8'h00, b);
    desel();
    chk("R12 first byte at top address", a, 8'hC3);
    chk("R12 address wraps to zero", b, 8'h3C);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sck = 1'b0; cs_n = 1'b1; si = 1'b0; hold_n = 1'b1; wp_n = 1'b1;
    wclk(5);
    rst = 1'b0;
    wclk(3);
    t_reset();
    t_write_read();
    t_status_busy();
    t_deselected();
    t_protect();
    t_busy_reject();
    t_partial();
    t_hold_resume();
    t_hold_entry();
    t_hold_busy();
    t_wrap();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule